// File: doc/BRIEF.md
# Speculative Load Address Table

This block tracks loads that a compiler has hoisted above stores which might write the same memory. When such an early load executes, the pipeline records its destination register number and the byte range it read. Every later store compares its own byte range with all live records and drops any record it touches. When the program reaches the point where the load originally stood, it issues a check on the destination register. A record that is still present means no store interfered, and the early value may be used. A missing record means the value may be stale, and the pipeline must reissue the load or run recovery code.

Records are looked up by register number but removed by address overlap. The check reports failure when no record is found, never when one is. A check can either keep the record for a later check of the same load or consume it. The table is fully associative. When it is full, the oldest slot in round-robin order is reused. Losing a record this way only makes a later check fail, which is always safe.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset every record is invalid, so a check on any register reports a miss.
- R2: An advanced load (`ld_valid`) creates a record for `ld_reg` covering `ld_addr` and the size given by `ld_size`. A check on that register in any later cycle hits.
- R3: Sizes are encoded in `ld_size` and `st_size` as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. A store removes every record whose range shares at least one byte with the store's range, including partial overlap. The record is gone from the next cycle on.
- R4: A store whose range shares no byte with a record, including ranges that are only adjacent, leaves that record in place.
- R5: A check (`chk_valid`) is combinational on the table state at the start of the cycle. On a hit it raises `chk_hit`, keeps `chk_recover` low and drives `chk_miss_reg` to 0. With `chk_clear` low it changes nothing.
- R6: A check that finds no record raises `chk_recover` and reports the checked register on `chk_miss_reg` in the same cycle. When no check is presented, all three check outputs are 0.
- R7: A check with `chk_clear` high that hits removes the record, so the next check of the same register misses.
- R8: An advanced load to a register that already has a record replaces it. The old address range no longer protects the register, and at most one record exists per register.
- R9: A new record goes to the lowest free slot. When all slots are occupied, it replaces the slot named by a round-robin pointer, which starts at slot 0 after reset and advances by one on each such replacement.
- R10: When a store and an advanced load arrive in the same cycle, the store is applied first, so the new record survives even if the ranges overlap.
- R11: `flush_all` removes every record at the next clock edge and takes priority over an advanced load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate every record |
| ld_valid | input | 1 | Advanced load executes this cycle |
| ld_reg | input | REG_W | Destination register of the advanced load |
| ld_addr | input | ADDR_W | Base byte address read by the load |
| ld_size | input | 2 | Load size code (log2 of bytes) |
| st_valid | input | 1 | Store executes this cycle |
| st_addr | input | ADDR_W | Base byte address written by the store |
| st_size | input | 2 | Store size code (log2 of bytes) |
| chk_valid | input | 1 | Check executes this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_clear | input | 1 | Consume the record on a hit |
| chk_hit | output | 1 | Record present; speculative value is usable |
| chk_recover | output | 1 | Record absent; reissue or recover |
| chk_miss_reg | output | REG_W | Register to reissue on a miss, else 0 |

## Verification
The embedded properties assume that the base address plus the access size fits the address width, so a range never wraps past the top of memory. The stimulus uses only low addresses, which keeps it within this assumption. The properties also assume that at most one operation of each kind arrives per cycle and that reset is synchronous and low for at least one edge. The bench drives one set of port values per cycle and holds reset low across several edges. Same-cycle combinations, such as a store with a load or a consuming check with a load, are presented only where a requirement defines their order.

// File: rtl/sltab_pkg.sv
package sltab_pkg;

  // Size code is log2 of the access width in bytes.
  function automatic logic [3:0] span_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // Two byte ranges share a byte when each one starts before the other ends.
  function automatic logic ranges_overlap(input logic [63:0] a_base, input logic [1:0] a_sz,
                                          input logic [63:0] b_base, input logic [1:0] b_sz);
    logic [64:0] a_end;
    logic [64:0] b_end;
    a_end = {1'b0, a_base} + 65'(span_bytes(a_sz));
    b_end = {1'b0, b_base} + 65'(span_bytes(b_sz));
    return ({1'b0, a_base} < b_end) && ({1'b0, b_base} < a_end);
  endfunction

endpackage

// File: rtl/sltab_slot.sv
module sltab_slot #(
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_sz,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_sz,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_clear,
  output logic              valid_o,
  output logic [REG_W-1:0]  tag_o,
  output logic              chk_match_o,
  output logic              st_kill_o,
  output logic              drop_o,
  output logic              ld_same_o
);
  import sltab_pkg::*;

  logic              valid_q;
  logic [REG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        sz_q;

  assign valid_o     = valid_q;
  assign tag_o       = tag_q;
  assign chk_match_o = chk_valid && valid_q && (tag_q == chk_reg);
  assign st_kill_o   = st_valid && valid_q &&
                       ranges_overlap(64'(addr_q), sz_q, 64'(st_addr), st_sz);
  assign drop_o      = st_kill_o || (chk_match_o && chk_clear);
  assign ld_same_o   = valid_q && (tag_q == wr_reg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      addr_q  <= '0;
      sz_q    <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
      tag_q   <= wr_reg;
      addr_q  <= wr_addr;
      sz_q    <= wr_sz;
    end else if (drop_o) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sltab_victim.sv
module sltab_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_req,
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] same,
  output logic [IDX_W-1:0]   idx,
  output logic               evict
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] same_idx;
  logic [IDX_W-1:0] free_idx;
  logic             any_same;
  logic             any_free;

  always_comb begin
    same_idx = '0;
    any_same = 1'b0;
    free_idx = '0;
    any_free = 1'b0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (same[k]) begin
        same_idx = IDX_W'(k);
        any_same = 1'b1;
      end
      if (!live[k]) begin
        free_idx = IDX_W'(k);
        any_free = 1'b1;
      end
    end
    evict = alloc_req && !any_same && !any_free;
    idx   = any_same ? same_idx : (any_free ? free_idx : ptr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (evict) ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R9: the replacement pointer steps by exactly one slot per eviction.
  p_rr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evict |=> ptr_q == (($past(ptr_q) == IDX_W'(ENTRIES - 1)) ? '0 : $past(ptr_q) + 1'b1));

  p_rr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !evict |=> $stable(ptr_q));

endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker #(
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              ld_valid,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_clear,
  output logic              chk_hit,
  output logic              chk_recover,
  output logic [REG_W-1:0]  chk_miss_reg
);

  logic [ENTRIES-1:0] valid_q;
  logic [REG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] chk_match;
  logic [ENTRIES-1:0] st_kill;
  logic [ENTRIES-1:0] drop;
  logic [ENTRIES-1:0] ld_same;
  logic [ENTRIES-1:0] live_after;
  logic [IDX_W-1:0]   alloc_idx;
  logic               alloc_evict;
  logic               alloc_req;

  // Store and consuming check act first; the load then lands on what remains.
  assign live_after = valid_q & ~drop;
  assign alloc_req  = ld_valid && !flush_all;

  sltab_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (alloc_req),
    .live      (live_after),
    .same      (ld_same & live_after),
    .idx       (alloc_idx),
    .evict     (alloc_evict)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    sltab_slot #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush_all),
      .wr_en       (alloc_req && (alloc_idx == IDX_W'(i))),
      .wr_reg      (ld_reg),
      .wr_addr     (ld_addr),
      .wr_sz       (ld_size),
      .st_valid    (st_valid),
      .st_addr     (st_addr),
      .st_sz       (st_size),
      .chk_valid   (chk_valid),
      .chk_reg     (chk_reg),
      .chk_clear   (chk_clear),
      .valid_o     (valid_q[i]),
      .tag_o       (tag_q[i]),
      .chk_match_o (chk_match[i]),
      .st_kill_o   (st_kill[i]),
      .drop_o      (drop[i]),
      .ld_same_o   (ld_same[i])
    );
  end

  assign chk_hit      = |chk_match;
  assign chk_recover  = chk_valid && !chk_hit;
  assign chk_miss_reg = chk_recover ? chk_reg : '0;

  // R8: a register never owns two live records.
  p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $countones(chk_match) <= 1);

  // R2: the slot picked for an advanced load holds that register next cycle.
  p_alloc_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> valid_q[$past(alloc_idx)] && (tag_q[$past(alloc_idx)] == $past(ld_reg)));

  // R3: overlapped records are gone after the store.
  p_store_kill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !ld_valid && !flush_all) |=> (valid_q & $past(st_kill)) == '0);

  // R4: a store that overlaps nothing leaves the table as it was.
  p_store_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_kill == '0 && !ld_valid && !flush_all && !(chk_valid && chk_clear))
      |=> valid_q == $past(valid_q));

  // R5: a keeping check alone changes nothing.
  p_hit_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_hit && !chk_clear && !st_valid && !ld_valid && !flush_all) |=> valid_q == $past(valid_q));

  // R6: a miss always names the checked register.
  p_miss_names_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_match == '0) |-> (chk_recover && chk_miss_reg == chk_reg));

  // R7: a consuming check removes the record it hit.
  p_clear_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_hit && chk_clear && !ld_valid && !flush_all) |=> (valid_q & $past(chk_match)) == '0);

  // R11: invalidate-all empties the table.
  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> valid_q == '0);

endmodule

// File: tb/spec_load_tracker_test.sv
module spec_load_tracker_test;

  localparam int RW = 7;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush_all;
  logic          ld_valid;
  logic [RW-1:0] ld_reg;
  logic [AW-1:0] ld_addr;
  logic [1:0]    ld_size;
  logic          st_valid;
  logic [AW-1:0] st_addr;
  logic [1:0]    st_size;
  logic          chk_valid;
  logic [RW-1:0] chk_reg;
  logic          chk_clear;
  logic          chk_hit;
  logic          chk_recover;
  logic [RW-1:0] chk_miss_reg;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  spec_load_tracker uut (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr), .ld_size(ld_size),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_clear(chk_clear),
    .chk_hit(chk_hit), .chk_recover(chk_recover), .chk_miss_reg(chk_miss_reg)
  );

  typedef struct packed {
    logic [3:0]    req;
    logic          ldv;
    logic [RW-1:0] ldr;
    logic [AW-1:0] lda;
    logic [1:0]    lds;
    logic          stv;
    logic [AW-1:0] sta;
    logic [1:0]    sts;
    logic          ckv;
    logic [RW-1:0] ckr;
    logic          ckc;
    logic          hit;
  } vec_t;

  function automatic vec_t mk(int req, bit ldv, int ldr, int lda, int lds,
                              bit stv, int sta, int sts, bit ckv, int ckr, bit ckc, bit hit);
    vec_t v;
    v.req = 4'(req); v.ldv = ldv; v.ldr = RW'(ldr); v.lda = AW'(lda); v.lds = 2'(lds);
    v.stv = stv; v.sta = AW'(sta); v.sts = 2'(sts);
    v.ckv = ckv; v.ckr = RW'(ckr); v.ckc = ckc; v.hit = hit;
    return v;
  endfunction

  localparam int NV = 22;
  // Sizes: 0=1B 1=2B 2=4B 3=8B. A check sees the table before the same cycle's updates.
  localparam vec_t VECS [NV] = '{
    mk(1, 1, 5, 'h1000, 3, 0, 0, 0, 1, 5, 0, 0),      // R1 empty table misses
    mk(2, 0, 0, 0, 0, 0, 0, 0, 1, 5, 0, 1),           // R2 record present
    mk(4, 0, 0, 0, 0, 1, 'h2000, 2, 1, 5, 0, 1),      // R4 disjoint store
    mk(4, 0, 0, 0, 0, 0, 0, 0, 1, 5, 0, 1),           // R4 still present
    mk(3, 0, 0, 0, 0, 1, 'h1004, 2, 1, 5, 0, 1),      // R3 overlapping store
    mk(3, 0, 0, 0, 0, 0, 0, 0, 1, 5, 0, 0),           // R3 record gone
    mk(2, 1, 6, 'h1100, 2, 0, 0, 0, 0, 0, 0, 0),      // R2 load r6, 4B
    mk(4, 0, 0, 0, 0, 1, 'h1104, 2, 1, 6, 0, 1),      // R4 adjacent above
    mk(4, 0, 0, 0, 0, 1, 'h10FF, 0, 1, 6, 0, 1),      // R4 adjacent below 1B
    mk(4, 0, 0, 0, 0, 1, 'h10FE, 1, 1, 6, 0, 1),      // R4 adjacent below 2B
    mk(3, 0, 0, 0, 0, 1, 'h10FF, 1, 1, 6, 0, 1),      // R3 one shared byte
    mk(3, 0, 0, 0, 0, 0, 0, 0, 1, 6, 0, 0),           // R3 partial overlap killed
    mk(10, 1, 7, 'h3000, 0, 1, 'h3000, 3, 0, 0, 0, 0),// R10 store and load together
    mk(10, 0, 0, 0, 0, 0, 0, 0, 1, 7, 0, 1),          // R10 new record survived
    mk(7, 0, 0, 0, 0, 0, 0, 0, 1, 7, 1, 1),           // R7 consuming check hits
    mk(7, 0, 0, 0, 0, 0, 0, 0, 1, 7, 0, 0),           // R7 consumed
    mk(2, 1, 8, 'h4000, 3, 0, 0, 0, 0, 0, 0, 0),      // R2 load r8
    mk(8, 1, 8, 'h5000, 3, 0, 0, 0, 1, 8, 0, 1),      // R8 reload r8
    mk(8, 0, 0, 0, 0, 1, 'h4000, 3, 1, 8, 0, 1),      // R8 old range
    mk(8, 0, 0, 0, 0, 0, 0, 0, 1, 8, 0, 1),           // R8 old range no longer guards
    mk(3, 0, 0, 0, 0, 1, 'h5006, 1, 1, 8, 0, 1),      // R3 new range hit
    mk(3, 0, 0, 0, 0, 0, 0, 0, 1, 8, 0, 0)            // R3 new range killed
  };

  task automatic idle();
    flush_all = 0; ld_valid = 0; ld_reg = '0; ld_addr = '0; ld_size = '0;
    st_valid = 0; st_addr = '0; st_size = '0;
    chk_valid = 0; chk_reg = '0; chk_clear = 0;
  endtask

  // Compare outputs at the falling edge, then let the rising edge commit.
  task automatic check_and_tick(string tag, logic hit_e, logic rec_e, logic [RW-1:0] mr_e);
    @(negedge clk);
    n_checks++;
    if (chk_hit !== hit_e || chk_recover !== rec_e || chk_miss_reg !== mr_e) begin
      n_fail++;
      $display("FAIL %s: hit/recover/reg = %b/%b/%0d, expected %b/%b/%0d",
               tag, chk_hit, chk_recover, chk_miss_reg, hit_e, rec_e, mr_e);
    end
    @(posedge clk); #1;
    idle();
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic load(int r, int a, int s);
    ld_valid = 1; ld_reg = RW'(r); ld_addr = AW'(a); ld_size = 2'(s);
  endtask

  task automatic probe(string tag, int r, bit exp_hit);
    chk_valid = 1; chk_reg = RW'(r);
    check_and_tick(tag, exp_hit, !exp_hit, exp_hit ? '0 : RW'(r));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    idle();
    do_reset();

    // R6: no check presented means quiet outputs
    check_and_tick("R6 idle outputs", 1'b0, 1'b0, '0);

    foreach (VECS[n]) begin
      vec_t v;
      logic rec;
      v = VECS[n];
      ld_valid = v.ldv; ld_reg = v.ldr; ld_addr = v.lda; ld_size = v.lds;
      st_valid = v.stv; st_addr = v.sta; st_size = v.sts;
      chk_valid = v.ckv; chk_reg = v.ckr; chk_clear = v.ckc;
      rec = v.ckv && !v.hit;
      check_and_tick($sformatf("R%0d vector %0d", v.req, n), v.ckv && v.hit, rec,
                     rec ? v.ckr : '0);
    end

    // R1: reset in mid-run forgets live records
    load(20, 'h800, 2); tick();
    probe("R2 r20 present", 20, 1'b1);
    do_reset();
    probe("R1 r20 cleared by reset", 20, 1'b0);

    // R11: flush clears all and beats a same-cycle load
    load(1, 'h100, 3); tick();
    load(2, 'h200, 3); tick();
    flush_all = 1; load(3, 'h300, 3); tick();
    probe("R11 r1 flushed", 1, 1'b0);
    probe("R11 r2 flushed", 2, 1'b0);
    probe("R11 r3 load lost to flush", 3, 1'b0);

    // R9: fill from slot 0 upward, then evict round-robin from slot 0
    do_reset();
    for (int r = 10; r < 18; r++) begin
      load(r, 'h1000 + r * 16, 3); tick();
    end
    load(18, 'h2000, 3); tick();
    probe("R9 slot0 evicted", 10, 1'b0);
    probe("R9 slot1 kept", 11, 1'b1);
    probe("R9 newcomer present", 18, 1'b1);
    load(19, 'h2100, 3); tick();
    probe("R9 slot1 evicted next", 11, 1'b0);
    probe("R9 slot2 kept", 12, 1'b1);
    // R9: a freed slot is reused before any eviction
    st_valid = 1; st_addr = AW'('h1000 + 15 * 16); st_size = 2'd0; tick();
    load(21, 'h2200, 3); tick();
    probe("R9 free slot used", 21, 1'b1);
    probe("R9 no eviction of slot2", 12, 1'b1);
    probe("R9 no eviction of slot7", 17, 1'b1);

    finish_run();
  end

endmodule